// File: doc/BRIEF.md
# Prioritised Interrupt Distributor Slice

This block collects a small set of level-sensitive private interrupt lines and presents the single most urgent one to a CPU interface. Each line carries a programmable priority (smaller number is more urgent), an enable bit and a pending state that follows the sampled level of the line. Among all pending and enabled lines whose effective priority is strictly more urgent than a global priority mask, the most urgent one is forwarded. Ties go to the lowest line index. The output carries a valid flag, the line index and that line's effective priority.

Software reaches the block through a simple register bus with a combinational read. Enables are changed through separate write-one-to-set and write-one-to-clear registers. While a line stays pending and enabled, the priority it competes with is frozen. A new programmed value becomes effective once the line is seen deasserted, or once the line is disabled and re-enabled. Writing the clear-enable register starts a fixed-length recall. During the recall a busy bit in the control register reads 1, and it drops only after the disabled line has left the CPU interface output. Software can therefore disable a line, wait for busy to clear, reprogram the priority and re-enable the line, and the new priority takes effect at once.

Top module: `irq_dist`

## Requirements
- R1: After reset all enables read 0, every priority register reads 0xFF, the mask register reads 0x00, the control register reads 0 and `cpu_valid_o` is 0.
- R2: A write to the set-enable register (address 0x1) sets enable bit i for every data bit i that is 1 and leaves the other enable bits unchanged. Reads of address 0x1 or 0x2 return the enable vector, with bit i belonging to line i.
- R3: A write to the clear-enable register (address 0x2) clears enable bit i for every data bit i that is 1 and leaves the other enable bits unchanged.
- R4: Within SAMPLE_DIV+1 cycles of a level change, the output presents the candidate with the numerically smallest effective priority, with ties resolved to the lowest index. A candidate is a line that is pending, enabled and passes the mask. `cpu_id_o` carries the index, `cpu_prio_o` carries the effective priority, and `cpu_valid_o` is 0 when there is no candidate.
- R5: A line passes the mask (address 0x3) only if its effective priority is strictly less than the mask value. A mask of 0x00 blocks every line.
- R6: Line levels are sampled once every SAMPLE_DIV cycles and the pending bit takes the sampled value. A deassertion that falls between two samples changes neither the pending state nor the effective priority.
- R7: While a line is pending and enabled, a write to its priority register (address 0x4+i) leaves the effective priority unchanged. A read of that register returns the newly programmed value.
- R8: The effective priority takes the programmed value after the line is sampled low and then asserted again, or after the line is disabled and re-enabled.
- R9: Any write to the clear-enable register makes control bit 0 (busy, address 0x0) read 1 for the following RECALL_CYCLES cycles. A further clear-enable write during that time restarts the count.
- R10: A disabled line is never forwarded. A line that was being presented when it was disabled leaves the output before busy returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_IRQ | Level-sensitive interrupt lines |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address (write and read) |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data, combinational from the address |
| cpu_valid_o | output | 1 | An interrupt is presented to the CPU interface |
| cpu_id_o | output | ID_W | Index of the presented interrupt |
| cpu_prio_o | output | PRIO_W | Effective priority of the presented interrupt |

## Verification
The bench sweeps every combination of line levels against a set of mask values chosen just on and just off the programmed priorities, and it includes equal priorities. This catches an arbiter that breaks ties toward the higher index or that uses a less-or-equal mask compare. The bench aligns itself to the sampling phase by watching when the output first becomes valid. It then drives a one-cycle dip that must be missed and a long dip that must be seen. A design that refreshes priority on every register write would show the new value too early, and one that never refreshes would keep the stale value after the long dip. The recall checks count the busy cycles exactly and restart them with a second clear-enable write. They would expose a busy bit that clears early, one that ignores the restart, and a disabled line that is still presented after busy falls.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int unsigned ADDR_CTRL     = 0;
  localparam int unsigned ADDR_SETEN    = 1;
  localparam int unsigned ADDR_CLREN    = 2;
  localparam int unsigned ADDR_MASK     = 3;
  localparam int unsigned ADDR_PRIO0    = 4;
  localparam int unsigned CTRL_BUSY_BIT = 0;
endpackage

// File: rtl/irqd_sampler.sv
module irqd_sampler #(
  parameter int unsigned NUM_IRQ    = 4,
  parameter int unsigned SAMPLE_DIV = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] irq_i,
  output logic [NUM_IRQ-1:0] lvl_o
);
  localparam int unsigned CNT_W = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SAMPLE_DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  assign tick = (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_o <= '0;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + CNT_W'(1);
      if (tick) lvl_o <= irq_i;
    end
  end
endmodule

// File: rtl/irqd_regs.sv
module irqd_regs
  import irqd_pkg::*;
#(
  parameter int unsigned NUM_IRQ       = 4,
  parameter int unsigned PRIO_W        = 8,
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned ADDR_W        = 4,
  parameter int unsigned RECALL_CYCLES = 3
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [DATA_W-1:0]               wdata_i,
  output logic [DATA_W-1:0]               rdata_o,
  output logic [NUM_IRQ-1:0]              en_o,
  output logic [NUM_IRQ-1:0][PRIO_W-1:0]  prio_o,
  output logic [PRIO_W-1:0]               mask_o,
  output logic                            busy_o,
  output logic                            clr_we_o
);
  localparam int unsigned RC_W = $clog2(RECALL_CYCLES + 1);

  logic               set_we, mask_we;
  logic [NUM_IRQ-1:0] prio_we;
  logic [RC_W-1:0]    rc_q;
  logic               unused_wdata;

  assign set_we   = we_i && (addr_i == ADDR_W'(ADDR_SETEN));
  assign clr_we_o = we_i && (addr_i == ADDR_W'(ADDR_CLREN));
  assign mask_we  = we_i && (addr_i == ADDR_W'(ADDR_MASK));
  assign busy_o   = (rc_q != '0);
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= '0;
      mask_o <= '0;
      rc_q   <= '0;
    end else begin
      if (set_we)        en_o <= en_o | wdata_i[NUM_IRQ-1:0];
      else if (clr_we_o) en_o <= en_o & ~wdata_i[NUM_IRQ-1:0];
      if (mask_we) mask_o <= wdata_i[PRIO_W-1:0];
      // recall window restarts on every clear-enable write
      if (clr_we_o)        rc_q <= RC_W'(RECALL_CYCLES);
      else if (rc_q != '0) rc_q <= rc_q - RC_W'(1);
    end
  end

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_prio
    assign prio_we[g] = we_i && (addr_i == ADDR_W'(ADDR_PRIO0 + g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         prio_o[g] <= '1;
      else if (prio_we[g]) prio_o[g] <= wdata_i[PRIO_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(ADDR_CTRL))  rdata_o[CTRL_BUSY_BIT] = busy_o;
    if (addr_i == ADDR_W'(ADDR_SETEN)) rdata_o[NUM_IRQ-1:0] = en_o;
    if (addr_i == ADDR_W'(ADDR_CLREN)) rdata_o[NUM_IRQ-1:0] = en_o;
    if (addr_i == ADDR_W'(ADDR_MASK))  rdata_o[PRIO_W-1:0] = mask_o;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (addr_i == ADDR_W'(ADDR_PRIO0 + i)) rdata_o[PRIO_W-1:0] = prio_o[i];
    end
  end
endmodule

// File: rtl/irqd_arb.sv
module irqd_arb #(
  parameter int unsigned NUM_IRQ = 4,
  parameter int unsigned PRIO_W  = 8,
  parameter int unsigned ID_W    = 2
) (
  input  logic [NUM_IRQ-1:0]             pend_i,
  input  logic [NUM_IRQ-1:0]             en_i,
  input  logic [NUM_IRQ-1:0][PRIO_W-1:0] eff_i,
  input  logic [PRIO_W-1:0]              mask_i,
  output logic                           valid_o,
  output logic [ID_W-1:0]                id_o,
  output logic [PRIO_W-1:0]              prio_o
);
  logic [NUM_IRQ-1:0] cand;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_cand
    assign cand[g] = pend_i[g] && en_i[g] && (eff_i[g] < mask_i);
  end

  // strict compare in ascending index order keeps the lowest index on ties
  always_comb begin
    valid_o = 1'b0;
    id_o    = '0;
    prio_o  = '1;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (cand[i] && (!valid_o || (eff_i[i] < prio_o))) begin
        valid_o = 1'b1;
        id_o    = ID_W'(i);
        prio_o  = eff_i[i];
      end
    end
  end
endmodule

// File: rtl/irq_dist.sv
module irq_dist #(
  parameter int unsigned NUM_IRQ       = 4,
  parameter int unsigned PRIO_W        = 8,
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned ADDR_W        = 4,
  parameter int unsigned SAMPLE_DIV    = 4,
  parameter int unsigned RECALL_CYCLES = 3,
  localparam int unsigned ID_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               cpu_valid_o,
  output logic [ID_W-1:0]    cpu_id_o,
  output logic [PRIO_W-1:0]  cpu_prio_o
);
  logic [NUM_IRQ-1:0]             lvl_q;
  logic [NUM_IRQ-1:0]             en_q;
  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_q;
  logic [NUM_IRQ-1:0][PRIO_W-1:0] eff_q;
  logic [PRIO_W-1:0]              mask_q;
  logic                           busy;
  logic                           clr_we;
  logic                           arb_valid;
  logic [ID_W-1:0]                arb_id;
  logic [PRIO_W-1:0]              arb_prio;

  irqd_sampler #(
    .NUM_IRQ    (NUM_IRQ),
    .SAMPLE_DIV (SAMPLE_DIV)
  ) sampler_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .irq_i  (irq_i),
    .lvl_o  (lvl_q)
  );

  irqd_regs #(
    .NUM_IRQ       (NUM_IRQ),
    .PRIO_W        (PRIO_W),
    .DATA_W        (DATA_W),
    .ADDR_W        (ADDR_W),
    .RECALL_CYCLES (RECALL_CYCLES)
  ) regs_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .en_o     (en_q),
    .prio_o   (prio_q),
    .mask_o   (mask_q),
    .busy_o   (busy),
    .clr_we_o (clr_we)
  );

  // effective priority follows the register until the line is pending and enabled
  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_eff
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    eff_q[g] <= '1;
      else if (!(lvl_q[g] && en_q[g])) eff_q[g] <= prio_q[g];
    end
  end

  irqd_arb #(
    .NUM_IRQ (NUM_IRQ),
    .PRIO_W  (PRIO_W),
    .ID_W    (ID_W)
  ) arb_i (
    .pend_i  (lvl_q),
    .en_i    (en_q),
    .eff_i   (eff_q),
    .mask_i  (mask_q),
    .valid_o (arb_valid),
    .id_o    (arb_id),
    .prio_o  (arb_prio)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_valid_o <= 1'b0;
      cpu_id_o    <= '0;
      cpu_prio_o  <= '1;
    end else begin
      cpu_valid_o <= arb_valid;
      cpu_id_o    <= arb_id;
      cpu_prio_o  <= arb_prio;
    end
  end
endmodule

// File: rtl/irqd_chk.sv
module irqd_chk #(
  parameter int unsigned NUM_IRQ = 4,
  parameter int unsigned PRIO_W  = 8,
  parameter int unsigned ID_W    = 2
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic [NUM_IRQ-1:0]             lvl_i,
  input logic [NUM_IRQ-1:0]             en_i,
  input logic [NUM_IRQ-1:0][PRIO_W-1:0] eff_i,
  input logic [PRIO_W-1:0]              mask_i,
  input logic                           busy_i,
  input logic                           clr_we_i,
  input logic                           cpu_valid_i,
  input logic [ID_W-1:0]                cpu_id_i,
  input logic [PRIO_W-1:0]              cpu_prio_i
);
  logic [NUM_IRQ-1:0] pe_w;
  assign pe_w = lvl_i & en_i;

  // R10
  recall_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_valid_i && !busy_i) |-> en_i[cpu_id_i]);

  // R5
  mask_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_valid_i |-> (cpu_prio_i < $past(mask_i)));

  // R9
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> busy_i);

  // R9
  busy_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> !$past(clr_we_i));

  // R4
  valid_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_valid_i |-> (($past(pe_w) & (NUM_IRQ'(1) << cpu_id_i)) != '0));

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_frz
    // R7
    eff_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(pe_w[g]) |-> $stable(eff_i[g]));
  end
endmodule

bind irq_dist irqd_chk #(
  .NUM_IRQ (NUM_IRQ),
  .PRIO_W  (PRIO_W),
  .ID_W    (ID_W)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lvl_i       (lvl_q),
  .en_i        (en_q),
  .eff_i       (eff_q),
  .mask_i      (mask_q),
  .busy_i      (busy),
  .clr_we_i    (clr_we),
  .cpu_valid_i (cpu_valid_o),
  .cpu_id_i    (cpu_id_o),
  .cpu_prio_i  (cpu_prio_o)
);

// File: tb/irq_dist_tb_top.sv
module irq_dist_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N     = 4;
  localparam int SDIV  = 4;
  localparam int RCYC  = 3;
  localparam int AW    = 4;
  localparam int DW    = 32;
  localparam int IDW   = 2;
  localparam int WDOG  = 100000;
  localparam int A_CTRL = 0, A_SET = 1, A_CLR = 2, A_MASK = 3, A_PRIO = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq = '0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          cpu_valid;
  logic [IDW-1:0] cpu_id;
  logic [7:0]    cpu_prio;

  int nvec = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_dist #(
    .NUM_IRQ(N), .PRIO_W(8), .DATA_W(DW), .ADDR_W(AW),
    .SAMPLE_DIV(SDIV), .RECALL_CYCLES(RCYC)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .cpu_valid_o(cpu_valid), .cpu_id_o(cpu_id), .cpu_prio_o(cpu_prio)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    we = 1'b1; addr = AW'(a); wdata = DW'(d);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    addr = AW'(a);
    #1;
    d = rdata;
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    int pr[N];
    int masks[6];
    pr = '{32'h30, 32'h20, 32'h30, 32'h10};
    masks = '{32'h00, 32'h10, 32'h11, 32'h21, 32'h31, 32'hFF};

    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    // R1 reset state
    rd(A_CTRL, d); chk("R1", "ctrl", d, 0);
    rd(A_SET, d);  chk("R1", "enables", d, 0);
    rd(A_MASK, d); chk("R1", "mask", d, 0);
    for (int i = 0; i < N; i++) begin
      rd(A_PRIO + i, d); chk("R1", "prio", d, 32'hFF);
    end
    chk("R1", "valid", {31'b0, cpu_valid}, 0);

    // R2 set-enable
    wr(A_SET, 5); rd(A_SET, d); chk("R2", "set 0101", d, 5);
    wr(A_SET, 2); rd(A_SET, d); chk("R2", "set 0010", d, 7);
    rd(A_CLR, d); chk("R2", "read via clear addr", d, 7);
    // R3 clear-enable
    wr(A_CLR, 4); rd(A_SET, d); chk("R3", "clear 0100", d, 3);
    wr(A_CLR, 15); rd(A_SET, d); chk("R3", "clear all", d, 0);
    cyc(RCYC + 2);

    // R4 R5 sweep over levels and masks
    for (int i = 0; i < N; i++) wr(A_PRIO + i, pr[i]);
    wr(A_SET, 15);
    for (int m = 0; m < 6; m++) begin
      wr(A_MASK, masks[m]);
      for (int p = 0; p < (1 << N); p++) begin
        int bp;
        int bi;
        irq = N'(p);
        cyc(SDIV + 3);
        bp = 256; bi = -1;
        for (int i = 0; i < N; i++) begin
          if (p[i] && pr[i] < masks[m] && pr[i] < bp) begin
            bp = pr[i]; bi = i;
          end
        end
        chk("R4 R5", "valid", {31'b0, cpu_valid}, (bi >= 0) ? 1 : 0);
        if (bi >= 0) begin
          chk("R4", "id", {30'b0, cpu_id}, bi);
          chk("R4", "prio", {24'b0, cpu_prio}, bp);
        end
      end
    end
    irq = '0;
    cyc(SDIV + 3);

    // stale priority, sampling and refresh on line 0
    wr(A_CLR, 14);
    wr(A_PRIO, 32'h30);
    cyc(RCYC + 2);
    irq[0] = 1'b1;
    for (int k = 0; k < 4 * SDIV; k++) begin
      @(negedge clk);
      if (cpu_valid) break;
    end
    chk("R4", "line0 prio", {24'b0, cpu_prio}, 32'h30);
    wr(A_PRIO, 32'h10);
    cyc(2 * SDIV - 1);
    chk("R7", "frozen prio", {24'b0, cpu_prio}, 32'h30);
    rd(A_PRIO, d); chk("R7", "programmed readback", d, 32'h10);
    // one-cycle dip between samples
    irq[0] = 1'b0; cyc(1); irq[0] = 1'b1;
    cyc(SDIV + 2);
    chk("R6", "dip valid", {31'b0, cpu_valid}, 1);
    chk("R6", "dip prio", {24'b0, cpu_prio}, 32'h30);
    // long dip
    irq[0] = 1'b0; cyc(2 * SDIV);
    chk("R6", "long dip valid", {31'b0, cpu_valid}, 0);
    irq[0] = 1'b1; cyc(2 * SDIV);
    chk("R8", "refresh after reassert", {24'b0, cpu_prio}, 32'h10);

    // disable/recall/re-enable
    wr(A_PRIO, 32'h50);
    cyc(2 * SDIV);
    chk("R7", "frozen again", {24'b0, cpu_prio}, 32'h10);
    wr(A_CLR, 1);
    rd(A_CTRL, d); chk("R9", "busy t+0", d, 1);
    cyc(1);
    chk("R10", "recalled", {31'b0, cpu_valid}, 0);
    rd(A_CTRL, d); chk("R9", "busy t+1", d, 1);
    cyc(1); rd(A_CTRL, d); chk("R9", "busy t+2", d, 1);
    cyc(1); rd(A_CTRL, d); chk("R9", "busy done", d, 0);
    chk("R10", "not forwarded", {31'b0, cpu_valid}, 0);
    cyc(2 * SDIV);
    chk("R10", "stays off while pending", {31'b0, cpu_valid}, 0);
    wr(A_SET, 1);
    cyc(3);
    chk("R8", "reenable valid", {31'b0, cpu_valid}, 1);
    chk("R8", "reenable prio", {24'b0, cpu_prio}, 32'h50);

    // R9 restart by a second clear-enable write
    wr(A_CLR, 1);
    cyc(1);
    wr(A_CLR, 0);
    rd(A_CTRL, d); chk("R9", "restart t+0", d, 1);
    cyc(1); rd(A_CTRL, d); chk("R9", "restart t+1", d, 1);
    cyc(1); rd(A_CTRL, d); chk("R9", "restart t+2", d, 1);
    cyc(1); rd(A_CTRL, d); chk("R9", "restart done", d, 0);
    rd(A_SET, d); chk("R3", "zero data leaves enables", d, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule